// File: doc/BRIEF.md
# Word-Wide Descending Hardware Stack

This block keeps a last-in, first-out stack of 16-bit words in a small internal word RAM. A byte-offset stack pointer selects the top entry. The stack grows toward lower offsets: a push first steps the pointer down by two and then stores the word at the new top. A pop first reads the word at the current top and then steps the pointer up by two.

Software or a sequencer first loads the pointer with the bottom-of-stack offset. That offset is also kept as the floor for pops. The block combines a 16-bit segment value, shifted up by four bits, with the pointer to give a 24-bit physical address for the current top. Entries that have been popped are not cleared. They stay in the RAM until a later push writes over them.

Every request takes one clock. Rejected requests change nothing and raise a one-cycle flag. A successful pop delivers its word on a registered output, marked by a one-cycle valid strobe.

Top module: `word_stack`

## Requirements
- R1: After reset the pointer and the bottom value are both 0, all flags and the valid strobe are low, and a pop or a push in that state is rejected.
- R2: An accepted push makes sp_o equal to the old pointer minus 2 in the next cycle. It stores push_data_i at RAM word index (new pointer / 2) modulo the RAM depth.
- R3: An accepted pop makes sp_o equal to the old pointer plus 2 in the next cycle. pop_data_o then shows the word stored at word index (old pointer / 2).
- R4: A load sets both the pointer and the bottom value to sp_load_val_i with bit 0 cleared. A load takes priority over a push or a pop in the same cycle, and those requests are dropped.
- R5: tos_addr_o equals ({seg_base_i, 4'b0000} + sp_o) modulo 2^24, at all times.
- R6: A push and a pop requested in the same cycle without a load do nothing. conflict_o is high for the next cycle only.
- R7: A push requested while the pointer is below 2 is rejected. overflow_o is high for the next cycle, and the pointer and RAM are unchanged.
- R8: A pop requested while the pointer equals the bottom value is rejected. underflow_o is high for the next cycle, the pointer is unchanged, and pop_data_o keeps its last value.
- R9: pop_valid_o is high in exactly the cycle after an accepted pop and low otherwise. pop_data_o holds its value until the next accepted pop.
- R10: Pops and pushes never move stored words. Entries below the top read back the values they were pushed with, in last-in first-out order, even after other entries were popped and overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| push_data_i | input | 16 | Word to push |
| pop_i | input | 1 | Pop request |
| sp_load_i | input | 1 | Load pointer and bottom value |
| sp_load_val_i | input | 16 | Value to load, bit 0 ignored |
| seg_base_i | input | 16 | Stack segment value |
| pop_data_o | output | 16 | Last popped word |
| pop_valid_o | output | 1 | One-cycle strobe for pop_data_o |
| sp_o | output | 16 | Current stack pointer (byte offset) |
| tos_addr_o | output | 24 | Physical address of the top of stack |
| overflow_o | output | 1 | Push rejected, one cycle |
| underflow_o | output | 1 | Pop rejected, one cycle |
| conflict_o | output | 1 | Simultaneous push and pop rejected, one cycle |

## Verification
The bench builds the block with an 8-word RAM (RAM_AW = 3), so a full stack holds 8 words. With that depth, every pointer step from a 16-byte bottom down to zero can be checked, including the overflow at zero and the underflow on return to the bottom. Several bottom values and a segment value that changes on each step sweep the address sum and the edge cases of the RAM index. Interleaved pops and pushes then check that entries lower in the stack survive.

// File: rtl/word_stack_pkg.sv
package word_stack_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_LOAD,
    OP_PUSH,
    OP_POP,
    OP_CLASH
  } stk_op_e;

  function automatic stk_op_e decode_op(input logic push, input logic pop, input logic load);
    if (load)             return OP_LOAD;
    else if (push && pop) return OP_CLASH;
    else if (push)        return OP_PUSH;
    else if (pop)         return OP_POP;
    else                  return OP_IDLE;
  endfunction
endpackage

// File: rtl/word_stack_ptr.sv
module word_stack_ptr
  import word_stack_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int IDX_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stk_op_e          op_i,
  input  logic [PTR_W-1:0] load_val_i,
  output logic [PTR_W-1:0] sp_o,
  output logic             push_ok_o,
  output logic             pop_ok_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             overflow_o,
  output logic             underflow_o,
  output logic             conflict_o
);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(2);

  logic [PTR_W-1:0] sp_q, bot_q, sp_dec, sp_inc;
  logic [PTR_W-1:0] load_even;

  assign sp_dec    = sp_q - STEP;
  assign sp_inc    = sp_q + STEP;
  assign load_even = {load_val_i[PTR_W-1:1], 1'b0};

  assign push_ok_o = (op_i == OP_PUSH) && (sp_q >= STEP);
  assign pop_ok_o  = (op_i == OP_POP) && (sp_q != bot_q);
  assign wr_idx_o  = sp_dec[IDX_W:1];
  assign rd_idx_o  = sp_q[IDX_W:1];
  assign sp_o      = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q        <= '0;
      bot_q       <= '0;
      overflow_o  <= 1'b0;
      underflow_o <= 1'b0;
      conflict_o  <= 1'b0;
    end else begin
      overflow_o  <= (op_i == OP_PUSH) && !push_ok_o;
      underflow_o <= (op_i == OP_POP) && !pop_ok_o;
      conflict_o  <= (op_i == OP_CLASH);
      if (op_i == OP_LOAD) begin
        sp_q  <= load_even;
        bot_q <= load_even;
      end else if (push_ok_o) begin
        sp_q <= sp_dec;
      end else if (pop_ok_o) begin
        sp_q <= sp_inc;
      end
    end
  end
endmodule

// File: rtl/word_stack_mem.sv
module word_stack_mem #(
  parameter int DATA_W = 16,
  parameter int AW     = 5
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/word_stack_addr.sv
module word_stack_addr #(
  parameter int SEG_W  = 16,
  parameter int PTR_W  = 16,
  parameter int PHYS_W = 24
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [PTR_W-1:0]  sp_i,
  output logic [PHYS_W-1:0] addr_o
);
  localparam int SHW = SEG_W + 4;

  logic [SHW-1:0] seg_sh;

  assign seg_sh = {seg_i, 4'b0000};
  assign addr_o = PHYS_W'(seg_sh) + PHYS_W'(sp_i);
endmodule

// File: rtl/word_stack.sv
module word_stack
  import word_stack_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PTR_W  = 16,
  parameter int SEG_W  = 16,
  parameter int PHYS_W = 24,
  parameter int RAM_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              sp_load_i,
  input  logic [PTR_W-1:0]  sp_load_val_i,
  input  logic [SEG_W-1:0]  seg_base_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              pop_valid_o,
  output logic [PTR_W-1:0]  sp_o,
  output logic [PHYS_W-1:0] tos_addr_o,
  output logic              overflow_o,
  output logic              underflow_o,
  output logic              conflict_o
);
  stk_op_e            op;
  logic               push_ok, pop_ok;
  logic [RAM_AW-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0]  rd_word;

  assign op = decode_op(push_i, pop_i, sp_load_i);

  word_stack_ptr #(.PTR_W(PTR_W), .IDX_W(RAM_AW)) u_ptr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .load_val_i  (sp_load_val_i),
    .sp_o        (sp_o),
    .push_ok_o   (push_ok),
    .pop_ok_o    (pop_ok),
    .wr_idx_o    (wr_idx),
    .rd_idx_o    (rd_idx),
    .overflow_o  (overflow_o),
    .underflow_o (underflow_o),
    .conflict_o  (conflict_o)
  );

  word_stack_mem #(.DATA_W(DATA_W), .AW(RAM_AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (push_ok),
    .waddr_i (wr_idx),
    .wdata_i (push_data_i),
    .raddr_i (rd_idx),
    .rdata_o (rd_word)
  );

  word_stack_addr #(.SEG_W(SEG_W), .PTR_W(PTR_W), .PHYS_W(PHYS_W)) u_addr (
    .seg_i  (seg_base_i),
    .sp_i   (sp_o),
    .addr_o (tos_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pop_data_o  <= '0;
      pop_valid_o <= 1'b0;
    end else begin
      pop_valid_o <= pop_ok;
      if (pop_ok) pop_data_o <= rd_word;
    end
  end
endmodule

// File: rtl/word_stack_chk.sv
module word_stack_chk #(
  parameter int PTR_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_i,
  input logic             pop_i,
  input logic             sp_load_i,
  input logic [PTR_W-1:0] sp_o,
  input logic             pop_valid_o,
  input logic             overflow_o,
  input logic             underflow_o,
  input logic             conflict_o
);
  AST_PUSH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !sp_load_i && sp_o >= PTR_W'(2)) |=> (sp_o == $past(sp_o) - PTR_W'(2))); // R2

  AST_POP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !sp_load_i) |=> (underflow_o || sp_o == $past(sp_o) + PTR_W'(2))); // R3

  AST_CLASH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !sp_load_i) |=> (conflict_o && $stable(sp_o))); // R6

  AST_NO_OVERFLOW_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> $stable(sp_o)); // R7

  AST_NO_UNDERFLOW_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underflow_o |-> ($stable(sp_o) && !pop_valid_o)); // R8

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pop_valid_o, overflow_o, underflow_o, conflict_o})); // R9

  AST_EVEN_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sp_o[0]); // R4
endmodule

bind word_stack word_stack_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .sp_load_i   (sp_load_i),
  .sp_o        (sp_o),
  .pop_valid_o (pop_valid_o),
  .overflow_o  (overflow_o),
  .underflow_o (underflow_o),
  .conflict_o  (conflict_o)
);

// File: tb/word_stack_tb.sv
module word_stack_tb;
  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 1'b0, pop = 1'b0, load = 1'b0;
  logic [15:0] pdata = '0, lval = '0, seg = '0;
  logic [15:0] pop_data, sp;
  logic        pop_valid, ovf, unf, clash;
  logic [23:0] tos;

  int n_vec = 0, n_bad = 0;
  int sp_m = 0, bot_m = 0;
  logic [15:0] last_m = '0;
  logic [15:0] mem_m [DEPTH];

  always #5 clk = ~clk;

  word_stack #(.RAM_AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .push_data_i(pdata), .pop_i(pop),
    .sp_load_i(load), .sp_load_val_i(lval), .seg_base_i(seg), .pop_data_o(pop_data),
    .pop_valid_o(pop_valid), .sp_o(sp), .tos_addr_o(tos), .overflow_o(ovf),
    .underflow_o(unf), .conflict_o(clash)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] tos_exp();
    return 24'(({8'h0, seg} << 4) + 24'(sp_m));
  endfunction

  // drive on negedge, sample 1 ns after the next posedge, then check against the model
  task automatic step(input logic pu, input logic po, input logic ld, input logic [15:0] lv,
                      input logic [15:0] d);
    logic e_ovf, e_unf, e_clash, e_val;
    @(negedge clk);
    push = pu; pop = po; load = ld; lval = lv; pdata = d;
    e_ovf = 0; e_unf = 0; e_clash = 0; e_val = 0;
    if (ld) begin
      sp_m = int'(lv) & 32'hFFFE; bot_m = sp_m;
    end else if (pu && po) begin
      e_clash = 1;
    end else if (pu) begin
      if (sp_m < 2) e_ovf = 1;
      else begin sp_m -= 2; mem_m[(sp_m >> 1) % DEPTH] = d; end
    end else if (po) begin
      if (sp_m == bot_m) e_unf = 1;
      else begin last_m = mem_m[(sp_m >> 1) % DEPTH]; sp_m += 2; e_val = 1; end
    end
    @(posedge clk); #1;
    check("R2/R3/R4 sp", 32'(sp), 32'(sp_m));
    check("R7 overflow", 32'(ovf), 32'(e_ovf));
    check("R8 underflow", 32'(unf), 32'(e_unf));
    check("R6 conflict", 32'(clash), 32'(e_clash));
    check("R9 valid", 32'(pop_valid), 32'(e_val));
    check("R3/R10 pop data", 32'(pop_data), 32'(last_m));
    check("R5 tos", 32'(tos), 32'(tos_exp()));
  endtask

  task automatic idle();
    step(0, 0, 0, 16'h0, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem_m[i] = '0;
    #12;
    // R1: reset state
    check("R1 sp", 32'(sp), 0);
    check("R1 flags", {29'd0, ovf, unf, clash}, 0);
    check("R1 valid", 32'(pop_valid), 0);
    check("R1 tos", 32'(tos), 0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 1, 0, 0, 0);                    // R1 pop rejected
    step(1, 0, 0, 0, 16'h1111);             // R1 push rejected
    idle();
    step(0, 0, 1, 16'h0011, 0);             // R4 odd load forced even
    check("R4 even load", 32'(sp), 32'h10);

    // sweep bottoms: fill to overflow, drain to underflow (R2 R3 R7 R8 R9)
    for (int b = 16; b >= 2; b -= 2) begin
      seg = 16'(16'hF000 + b * 16'h0123);
      step(0, 0, 1, 16'(b), 0);
      for (int k = 0; k < b / 2; k++) begin
        seg = 16'(seg + 16'h0101);
        step(1, 0, 0, 0, 16'(b * 256 + k));
      end
      step(1, 0, 0, 0, 16'hDEAD);           // R7 at zero
      for (int k = 0; k < b / 2; k++) begin
        seg = 16'(seg + 16'h1011);
        step(0, 1, 0, 0, 0);
        check("R10 lifo", 32'(pop_data), 32'(b * 256 + (b / 2 - 1 - k)));
      end
      step(0, 1, 0, 0, 0);                  // R8 at bottom, data held
      idle();                               // R9 strobe low
    end

    // R6 clash, R4 load priority
    seg = 16'hFFFF;
    step(0, 0, 1, 16'h000C, 0);
    step(1, 0, 0, 0, 16'hA001);
    step(1, 1, 0, 0, 16'hBEEF);
    step(0, 1, 0, 0, 0);
    check("R6 clash no write", 32'(pop_data), 32'hA001);
    step(1, 0, 1, 16'h0008, 16'hCAFE);      // R4 load wins
    step(0, 1, 1, 16'h0006, 0);             // R4 load wins over pop
    step(0, 1, 0, 0, 0);                    // R4 then underflow

    // R10: lower entries survive pops and overwrites
    step(0, 0, 1, 16'h000E, 0);
    step(1, 0, 0, 0, 16'h0A0A);
    step(1, 0, 0, 0, 16'h0B0B);
    step(1, 0, 0, 0, 16'h0C0C);
    step(0, 1, 0, 0, 0);
    step(1, 0, 0, 0, 16'h0D0D);
    step(0, 1, 0, 0, 0);
    check("R10 new top", 32'(pop_data), 32'h0D0D);
    step(0, 1, 0, 0, 0);
    check("R10 kept", 32'(pop_data), 32'h0B0B);
    step(0, 1, 0, 0, 0);
    check("R10 kept", 32'(pop_data), 32'h0A0A);
    idle();

    // R5: address sum over segment extremes
    for (int s = 0; s < 16; s++) begin
      seg = 16'(s * 16'h1111);
      idle();
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule